// File: doc/BRIEF.md
# I2C Target with Twelve-Entry Register Bank

This block is an I2C target that holds twelve 10-bit registers. A controller can write or read them over the bus. A transaction starts at a register chosen by an index byte. It may cover a single register or a run of consecutive ones, because the index steps forward after every complete two-byte value. SCL and SDA come in as raw pad inputs and are oversampled by the system clock. SDA is driven only as an open-drain pull-down enable. The whole bank is presented in parallel. A one-cycle strobe marks the register that has just taken a new value, so downstream logic can react to each commit.

A write carries the device address with the direction bit low, then the index byte, then pairs of data bytes. In each pair the high byte comes first and supplies only bits 9:8, and the low byte supplies bits 7:0. A value is committed only once its low byte has fully arrived. To read, the controller writes the index byte, issues a repeated START and sends the address with the direction bit high. The target then returns high byte, low byte, next register and so on, for as long as the controller acknowledges.

The protocol engine is an explicit state machine:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the acknowledge.
- `ST_INDEX` and `ST_INDEX_ACK` take the index byte.
- `ST_WDATA` and `ST_WDATA_ACK` take write data.
- `ST_RDATA` shifts a byte out, and `ST_RACK` samples the controller's acknowledge.
- `ST_IGNORE` stays off the bus until the next START.

Transitions:
- START from any state goes to `ST_ADDR`, and STOP from any state goes to `ST_IDLE`.
- A matching address leads to `ST_ADDR_ACK`, and a mismatch leads to `ST_IGNORE`.
- After the address acknowledge, the direction bit selects `ST_INDEX` or `ST_RDATA`.
- A refused index leads to `ST_IGNORE`.
- `ST_WDATA_ACK` returns to `ST_WDATA`.
- In `ST_RACK`, an acknowledge returns to `ST_RDATA` and a not-acknowledge leads to `ST_IGNORE`.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte whose upper seven bits equal the `DEV_ADDR` parameter (default 7'h48) is acknowledged. Any other address gets no acknowledge, and the target leaves SDA released for every later byte until the next START.
- R2: In the index byte, bits 3:0 select the register and bits 7:4 are ignored. Values 0 to 11 are acknowledged. Values 12 to 15 are refused with a not-acknowledge, and no following write byte is acknowledged or stored.
- R3: A write pair sets the addressed register to {first byte bits 1:0, second byte bits 7:0}. The upper six bits of the first byte are ignored. The register changes only after the second byte, and `commit_stb` bit i pulses for exactly one clock when register i commits.
- R4: A STOP or a repeated START that arrives after the first byte of a pair discards that byte. The register keeps its old value and no strobe is raised.
- R5: After each complete write pair the index advances by one, so a single transaction can load all twelve registers with 24 data bytes.
- R6: Once the index has moved past 11, further write bytes get a not-acknowledge and change no register.
- R7: A read returns the selected register as a high byte, whose bits 7:2 are zero and bits 1:0 are register bits 9:8, followed by a low byte. While the controller acknowledges, the read continues through the following registers in order.
- R8: Reads past index 11 return 0x00. A controller not-acknowledge or a STOP makes the target release SDA.
- R9: After reset all registers read zero, no strobe is active and SDA is released.
- R10: The target changes its SDA drive only while the synchronized SCL is low.
- R11: At most one strobe bit is high in any cycle, and a register value never changes without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | When high, SDA is pulled low |
| reg_flat | output | NUM_REGS*REG_W | All registers; register i occupies bits [i*REG_W +: REG_W] |
| commit_stb | output | NUM_REGS | One-cycle pulse on bit i when register i commits |

## Verification
The bound checker watches several rules on every cycle:
- SDA drive changes only while SCL is low.
- A refused index never drives an acknowledge.
- The target is off the bus when idle and right after a STOP.
- No commit targets an out-of-range index, and strobes are one-hot.
- Register values change only together with a strobe.

Some behaviour only the bench scenarios can show, because it depends on whole transactions:
- the value assembled from two bytes;
- the loss of a half-written value when a transfer is aborted;
- auto-increment across the bank and past its end;
- the byte order and zero padding of read data.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int BYTE_W      = 8;
    localparam int IDX_FIELD_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // bus idles high, so every stage resets to one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_q    <= scl_pipe[TOP];
            sda_q    <= sda_pipe[TOP];
        end
    end

    assign scl_s     = scl_pipe[TOP];
    assign sda_s     = sda_pipe[TOP];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edge while clock is held high marks a frame boundary
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int REG_W    = 10,
    parameter int IDX_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      rd_half,
    output logic [NUM_REGS*REG_W-1:0] regs_flat,
    output logic [NUM_REGS-1:0]       commit_stb,
    output logic [BYTE_W-1:0]         rd_byte
);
    logic [REG_W-1:0] reg_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[g]      <= '0;
                commit_stb[g] <= 1'b0;
            end else begin
                commit_stb[g] <= hit;
                if (hit) begin
                    reg_q[g] <= wr_data;
                end
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = reg_q[g];
    end

    // out-of-range index reads as zero; high byte is zero-padded
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                if (rd_half) begin
                    rd_byte = reg_q[i][BYTE_W-1:0];
                end else begin
                    rd_byte = BYTE_W'(reg_q[i][REG_W-1:BYTE_W]);
                end
            end
        end
    end

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NUM_REGS = 12,
    parameter int         REG_W    = 10,
    parameter int         IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [REG_W-1:0]  wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_half,
    output tgt_state_e        state_o,
    output logic              ack_ok_o
);
    localparam int CNT_W = 4;
    localparam int HI_W  = REG_W - BYTE_W;

    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [IDX_W-1:0]  idx_q;
    logic              half_q;
    logic [HI_W-1:0]   hi_q;
    logic              rw_q;
    logic              ack_ok_q;
    logic              m_ack_q;
    logic              sda_oe_q;

    logic byte_end, ack_end, active, idx_in_range, field_ok, addr_hit;

    assign byte_end     = scl_fall && (cnt_q == CNT_W'(8));
    assign ack_end      = scl_fall && (cnt_q == CNT_W'(1));
    assign active       = (state_q != ST_IDLE) && (state_q != ST_IGNORE);
    assign idx_in_range = int'(idx_q) < NUM_REGS;
    assign field_ok     = int'(rx_q[IDX_FIELD_W-1:0]) < NUM_REGS;
    assign addr_hit     = (rx_q[BYTE_W-1:1] == DEV_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (ack_end)  state_d = rw_q ? ST_RDATA : ST_INDEX;
                ST_INDEX:     if (byte_end) state_d = ST_INDEX_ACK;
                ST_INDEX_ACK: if (ack_end)  state_d = ack_ok_q ? ST_WDATA : ST_IGNORE;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_end)  state_d = ST_WDATA;
                ST_RDATA:     if (byte_end) state_d = ST_RACK;
                ST_RACK:      if (ack_end)  state_d = m_ack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            idx_q    <= '0;
            half_q   <= 1'b0;
            hi_q     <= '0;
            rw_q     <= 1'b0;
            ack_ok_q <= 1'b0;
            m_ack_q  <= 1'b0;
            sda_oe_q <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                // frame boundary: partial pair is dropped, index is kept
                cnt_q    <= '0;
                half_q   <= 1'b0;
                sda_oe_q <= 1'b0;
            end else begin
                if (scl_rise && active) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
                    if (state_q == ST_RACK) begin
                        m_ack_q <= ~sda_s;
                    end
                end
                unique case (state_q)
                    ST_ADDR: if (byte_end) begin
                        cnt_q    <= '0;
                        rw_q     <= rx_q[0];
                        sda_oe_q <= addr_hit;
                    end
                    ST_ADDR_ACK: if (ack_end) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            tx_q     <= rd_byte;
                            sda_oe_q <= ~rd_byte[BYTE_W-1];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    ST_INDEX: if (byte_end) begin
                        cnt_q    <= '0;
                        ack_ok_q <= field_ok;
                        sda_oe_q <= field_ok;
                        if (field_ok) begin
                            idx_q  <= IDX_W'(rx_q[IDX_FIELD_W-1:0]);
                            half_q <= 1'b0;
                        end
                    end
                    ST_WDATA: if (byte_end) begin
                        cnt_q    <= '0;
                        sda_oe_q <= idx_in_range;
                        if (idx_in_range) begin
                            if (!half_q) begin
                                hi_q   <= rx_q[HI_W-1:0];
                                half_q <= 1'b1;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_idx  <= idx_q;
                                wr_data <= {hi_q, rx_q};
                                idx_q   <= idx_q + IDX_W'(1);
                                half_q  <= 1'b0;
                            end
                        end
                    end
                    ST_INDEX_ACK, ST_WDATA_ACK: if (ack_end) begin
                        cnt_q    <= '0;
                        sda_oe_q <= 1'b0;
                    end
                    ST_RDATA: if (scl_fall) begin
                        if (cnt_q == CNT_W'(8)) begin
                            cnt_q    <= '0;
                            sda_oe_q <= 1'b0;
                            if (half_q) begin
                                half_q <= 1'b0;
                                if (idx_in_range) begin
                                    idx_q <= idx_q + IDX_W'(1);
                                end
                            end else begin
                                half_q <= 1'b1;
                            end
                        end else if (cnt_q != '0) begin
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~tx_q[BYTE_W-2];
                        end
                    end
                    ST_RACK: if (ack_end) begin
                        cnt_q <= '0;
                        if (m_ack_q) begin
                            tx_q     <= rd_byte;
                            sda_oe_q <= ~rd_byte[BYTE_W-1];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe   = sda_oe_q;
    assign rd_idx   = idx_q;
    assign rd_half  = half_q;
    assign state_o  = state_q;
    assign ack_ok_o = ack_ok_q;

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 12,
    parameter int         REG_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [NUM_REGS*REG_W-1:0] reg_flat,
    output logic [NUM_REGS-1:0]       commit_stb
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, rd_half, ack_ok;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [REG_W-1:0]  wr_data;
    logic [BYTE_W-1:0] rd_byte;
    tgt_state_e        fsm_state;

    i2c_rb_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .IDX_W    (IDX_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_half   (rd_half),
        .state_o   (fsm_state),
        .ack_ok_o  (ack_ok)
    );

    i2c_rb_bank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .IDX_W    (IDX_W)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_half    (rd_half),
        .regs_flat  (reg_flat),
        .commit_stb (commit_stb),
        .rd_byte    (rd_byte)
    );

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int REG_W    = 10,
    parameter int IDX_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      scl_s,
    input logic                      sda_oe,
    input logic                      stop_det,
    input logic                      wr_en,
    input logic [IDX_W-1:0]          wr_idx,
    input logic [NUM_REGS-1:0]       commit_stb,
    input logic [NUM_REGS*REG_W-1:0] regs_flat,
    input tgt_state_e                state,
    input logic                      ack_ok
);

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    p_nack_bad_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INDEX_ACK && !ack_ok) |-> !sda_oe);

    p_stb_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb != '0) |-> $past(wr_en));

    p_commit_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);

    p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    p_stb_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_stb));

    p_reg_change_needs_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_flat != $past(regs_flat)) |-> (commit_stb != '0));

endmodule

bind i2c_regbank_target i2c_rb_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_oe     (sda_oe),
    .stop_det   (stop_det),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .commit_stb (commit_stb),
    .regs_flat  (reg_flat),
    .state      (fsm_state),
    .ack_ok     (ack_ok)
);

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;
    localparam int         NREG = 12;
    localparam int         RW   = 10;
    localparam logic [6:0] ADDR = 7'h48;
    localparam int         Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_pull = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [NREG*RW-1:0] reg_flat;
    logic [NREG-1:0]    commit_stb;

    always #2.5 clk = ~clk;

    assign sda_line = ~(sda_pull | sda_oe);

    i2c_regbank_target #(.DEV_ADDR(ADDR)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .reg_flat   (reg_flat),
        .commit_stb (commit_stb)
    );

    int checks = 0;
    int errors = 0;
    int stb_total = 0;
    int exp_commits = 0;
    int r10_viol = 0;
    int r11_viol = 0;
    logic [RW-1:0] model [NREG];
    logic [7:0]    wbuf [32];
    logic [7:0]    rbuf [32];
    bit            ack_buf [32];
    bit            exp_ack [32];
    bit            a_ack, i_ack;
    logic          prev_oe = 1'b0;
    logic [NREG*RW-1:0] prev_regs = '0;

    // monitors for strobe count, drive timing and register stability
    always @(negedge clk) begin
        if (rst_n) begin
            if (commit_stb != '0) stb_total++;
            if ($countones(commit_stb) > 1) r11_viol++;
            if (reg_flat != prev_regs && commit_stb == '0) r11_viol++;
            if (sda_oe != prev_oe && scl_drv) r10_viol++;
        end
        prev_oe   = sda_oe;
        prev_regs = reg_flat;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] get_reg(input int i);
        return reg_flat[i*RW +: RW];
    endfunction

    function automatic logic [7:0] exp_rd(input int idx, input bit half);
        if (idx >= NREG) return 8'h00;
        return half ? model[idx][7:0] : {6'b0, model[idx][9:8]};
    endfunction

    task automatic model_apply(input int sidx, input int n);
        int idx = sidx;
        bit half = 0;
        logic [1:0] hi = 0;
        for (int k = 0; k < n; k++) begin
            if (idx < NREG) begin
                exp_ack[k] = 1;
                if (!half) begin
                    hi = wbuf[k][1:0];
                    half = 1;
                end else begin
                    model[idx] = {hi, wbuf[k]};
                    idx++;
                    half = 0;
                    exp_commits++;
                end
            end else begin
                exp_ack[k] = 0;
            end
        end
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gen_start();
        sda_pull = 0; bus_wait(Q);
        scl_drv = 1; bus_wait(Q);
        sda_pull = 1; bus_wait(Q);
        scl_drv = 0; bus_wait(2);
    endtask

    task automatic gen_stop();
        sda_pull = 1; bus_wait(Q);
        scl_drv = 1; bus_wait(Q);
        sda_pull = 0; bus_wait(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_pull = ~b[i]; bus_wait(Q);
            scl_drv = 1; bus_wait(Q);
            scl_drv = 0; bus_wait(2);
        end
        sda_pull = 0; bus_wait(Q);
        scl_drv = 1; bus_wait(Q / 2);
        acked = (sda_line == 1'b0);
        bus_wait(Q / 2);
        scl_drv = 0; bus_wait(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_pull = 0;
        for (int i = 7; i >= 0; i--) begin
            bus_wait(Q);
            scl_drv = 1; bus_wait(Q / 2);
            b[i] = sda_line;
            bus_wait(Q / 2);
            scl_drv = 0; bus_wait(2);
        end
        sda_pull = give_ack; bus_wait(Q);
        scl_drv = 1; bus_wait(Q);
        scl_drv = 0; bus_wait(2);
        sda_pull = 0;
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] ib, input int n);
        gen_start();
        send_byte({a, 1'b0}, a_ack);
        send_byte(ib, i_ack);
        for (int k = 0; k < n; k++) send_byte(wbuf[k], ack_buf[k]);
        gen_stop();
    endtask

    task automatic read_txn(input logic [7:0] ib, input int n);
        gen_start();
        send_byte({ADDR, 1'b0}, a_ack);
        send_byte(ib, i_ack);
        gen_start();
        send_byte({ADDR, 1'b1}, a_ack);
        for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
        gen_stop();
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(get_reg(i) == model[i], tag, int'(get_reg(i)), int'(model[i]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c2d));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        bus_wait(5);
        rst_n = 1;
        bus_wait(5);

        // R9: reset state
        chk(reg_flat == '0, "R9 regs zero", int'(reg_flat[31:0]), 0);
        chk(commit_stb == '0 && sda_oe == 1'b0, "R9 no stb, sda released",
            int'({commit_stb, sda_oe}), 0);

        // R1: foreign address ignored
        wbuf[0] = 8'h03; wbuf[1] = 8'hFF;
        write_txn(7'h21, 8'h00, 2);
        chk(!a_ack && !i_ack && !ack_buf[0] && !ack_buf[1], "R1 foreign addr no ack",
            int'({a_ack, i_ack, ack_buf[0], ack_buf[1]}), 0);
        check_regs("R1 regs untouched");

        // R2 + R3: upper index bits ignored, upper first-byte bits ignored
        wbuf[0] = 8'hFE; wbuf[1] = 8'hA5;
        write_txn(ADDR, 8'hF3, 2);
        model_apply(3, 2);
        chk(a_ack && i_ack && ack_buf[0] && ack_buf[1], "R3 write acks",
            int'({a_ack, i_ack, ack_buf[0], ack_buf[1]}), 15);
        chk(get_reg(3) == 10'h2A5, "R2 R3 reg3 value", int'(get_reg(3)), 'h2A5);
        chk(stb_total == exp_commits, "R3 one strobe", stb_total, exp_commits);

        // R2: out-of-range index refused, following bytes not stored
        wbuf[0] = 8'h01; wbuf[1] = 8'h11;
        write_txn(ADDR, 8'h0C, 2);
        chk(a_ack && !i_ack && !ack_buf[0], "R2 index 12 nack",
            int'({a_ack, i_ack, ack_buf[0]}), 4);
        write_txn(ADDR, 8'h0F, 2);
        chk(!i_ack, "R2 index 15 nack", int'(i_ack), 0);
        check_regs("R2 regs untouched");

        // R4: STOP after first byte discards it
        wbuf[0] = 8'h03;
        write_txn(ADDR, 8'h05, 1);
        chk(get_reg(5) == model[5] && stb_total == exp_commits, "R4 stop abort",
            int'(get_reg(5)), int'(model[5]));

        // R4: repeated START after first byte discards it
        gen_start();
        send_byte({ADDR, 1'b0}, a_ack);
        send_byte(8'h06, i_ack);
        send_byte(8'h02, ack_buf[0]);
        gen_start();
        send_byte({ADDR, 1'b0}, a_ack);
        send_byte(8'h07, i_ack);
        send_byte(8'h01, ack_buf[0]);
        send_byte(8'h3C, ack_buf[1]);
        gen_stop();
        model[7] = 10'h13C; exp_commits++;
        chk(get_reg(6) == model[6], "R4 restart abort keeps reg6", int'(get_reg(6)), int'(model[6]));
        chk(get_reg(7) == 10'h13C, "R4 reg7 after restart", int'(get_reg(7)), 'h13C);

        // R5 + R6: full bank write, then two extra bytes past the end
        for (int k = 0; k < 26; k++) wbuf[k] = 8'(k * 37 + 5);
        write_txn(ADDR, 8'h00, 26);
        model_apply(0, 26);
        check_regs("R5 full bank");
        chk(!ack_buf[24] && !ack_buf[25], "R6 nack past end",
            int'({ack_buf[24], ack_buf[25]}), 0);
        chk(stb_total == exp_commits, "R5 R6 strobe count", stb_total, exp_commits);

        // R7: read two registers from index 10
        read_txn(8'h0A, 4);
        for (int k = 0; k < 4; k++)
            chk(rbuf[k] == exp_rd(10 + k / 2, k[0]), "R7 read data",
                int'(rbuf[k]), int'(exp_rd(10 + k / 2, k[0])));
        chk(rbuf[0][7:2] == 6'b0, "R7 high byte padding", int'(rbuf[0]), int'(exp_rd(10, 0)));

        // R8: read past the end, release after controller NACK
        read_txn(8'h0B, 6);
        for (int k = 2; k < 6; k++)
            chk(rbuf[k] == 8'h00, "R8 past end zero", int'(rbuf[k]), 0);
        chk(sda_oe == 1'b0, "R8 released", int'(sda_oe), 0);

        // random writes and read-backs
        for (int it = 0; it < 20; it++) begin
            int sidx = $urandom_range(0, NREG - 1);
            int n = $urandom_range(1, 6);
            int ridx = $urandom_range(0, NREG - 1);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_txn(ADDR, 8'(sidx), n);
            model_apply(sidx, n);
            for (int k = 0; k < n; k++)
                chk(ack_buf[k] == exp_ack[k], "R6 random ack", int'(ack_buf[k]), int'(exp_ack[k]));
            check_regs("R5 random write");
            read_txn(8'(ridx), 4);
            for (int k = 0; k < 4; k++)
                chk(rbuf[k] == exp_rd(ridx + k / 2, k[0]), "R7 random read",
                    int'(rbuf[k]), int'(exp_rd(ridx + k / 2, k[0])));
        end

        chk(stb_total == exp_commits, "R3 total strobes", stb_total, exp_commits);
        chk(r10_viol == 0, "R10 drive moved with SCL high", r10_viol, 0);
        chk(r11_viol == 0, "R11 strobe rules", r11_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule